// File: doc/BRIEF.md
# Buffered SPI Master Serial Port

This block is a serial-port core that runs only as an SPI master. The CPU side has three operations. A write to the data location queues one byte and starts a transfer. A read of the same location returns the oldest received byte. Two status flags report that the transmit holding register is empty and that received data is waiting. The block makes its own transfer clock from a programmable divider. It shifts one byte out and one byte in during each transfer. Clock polarity, clock phase and bit order are chosen by configuration inputs.

A transfer starts only when the CPU writes a byte, even when the CPU only wants to read. Each byte sent brings one byte back, and the CPU must read that byte to keep the receive side in step. The receive side holds two bytes in a queue, plus one more completed byte that waits its turn. When that waiting byte is replaced before it reaches the queue, it is lost and an overrun flag is raised. The bytes already queued are kept. When the transmit enable is set, the block drives the serial output pin. When the receive enable is clear, incoming bits are not stored, but the clock still runs for each transfer.

Top module: `spim_core`

## Requirements
- R1: After a synchronous reset, `txbuf_empty` is 1, `rx_ready` is 0, `overrun` is 0, `mosi` is 0, `mosi_oe` is 0, and `sck` equals `cpol`.
- R2: While `tx_en` is 0, writes are dropped and no clock edge is made. Setting `tx_en` to 1 later does not start a transfer for the dropped byte. `mosi_oe` equals `tx_en`.
- R3: While a byte is shifted, each level of `sck` lasts `clk_div`+1 system clocks. Each byte makes 16 edges. When no transfer is running, `sck` equals `cpol`.
- R4: Bit order: with `lsb_first`=0, bit 7 is sent first; with `lsb_first`=1, bit 0 is sent first. Clock phase: with `cpha`=0, `mosi` is valid before the first edge of the byte and changes on every second edge (the trailing edges); with `cpha`=1, `mosi` changes on the first edge of each bit (the leading edges). A slave that samples on the opposite edge reads the written byte.
- R5: `miso` is sampled on the leading edge when `cpha`=0 and on the trailing edge when `cpha`=1. Bits are placed in the same order that R4 uses. The completed byte appears on `rd_data`.
- R6: An accepted write clears `txbuf_empty`. The flag is set again on the clock after the byte moves into the idle shifter. While the shifter is busy, the flag stays clear.
- R7: If the holding register is full when a byte ends, the next byte is loaded on that same tick. Edge spacing then stays `clk_div`+1 clocks across the byte boundary.
- R8: While `rx_en` is 0, completed bytes are not stored and `rx_ready` stays 0, but transfers still clock out.
- R9: Received bytes are read in arrival order, and `rx_ready` stays 1 until every stored byte has been read. Each `rd_en` pulse with `rx_ready`=1 removes one byte.
- R10: With two bytes queued and one byte waiting, a further completed byte replaces the waiting byte. That waiting byte is lost and `overrun` goes to 1. After four transfers with no reads, the reads return bytes 1, 2 and 4. `overrun` clears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; gates writes and drives the output pin |
| rx_en | input | 1 | Receiver enable; gates storing of received bytes |
| cpol | input | 1 | Idle level of the transfer clock |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first | input | 1 | 1: shift bit 0 first, 0: shift bit 7 first |
| clk_div | input | 12 | Half-period of the transfer clock minus one, in system clocks |
| wr_en | input | 1 | Write strobe for the data location |
| wr_data | input | 8 | Byte to send |
| rd_en | input | 1 | Read strobe; removes the head received byte |
| miso | input | 1 | Serial input from the slave |
| rd_data | output | 8 | Oldest received byte |
| txbuf_empty | output | 1 | Transmit holding register is empty |
| rx_ready | output | 1 | At least one received byte is waiting |
| overrun | output | 1 | A received byte was lost |
| sck | output | 1 | Transfer clock |
| mosi | output | 1 | Serial output to the slave |
| mosi_oe | output | 1 | Serial output pin is driven by the block |

## Verification
Single transfers run through all four polarity/phase pairs, in both bit orders, with divider values from 0 to 5. The slave model sends back a byte that differs from the one written. A swap of sample and drive edges therefore shows up, and so does a reversed bit order or a mistimed half-period. A four-byte burst with no reads in between tests two things at once. The gap-free clock shows whether loading takes extra cycles. The read-back order 1, 2, 4 shows whether the newest byte is the one dropped. Runs with each enable cleared separate the gating of writes, the storing of received bytes and the clock itself.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_mode_t;

    // Bit number k of the serial order
    function automatic logic bit_at(logic [DATA_W-1:0] d, logic [IDX_W-1:0] k, logic lsb);
        logic [IDX_W-1:0] pos;
        pos = lsb ? k : (IDX_W'(DATA_W - 1) - k);
        return d[pos];
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_mode_t         mode,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);
    localparam int H_W = $clog2(2 * DATA_W);

    logic [H_W-1:0]    half;
    logic              phase;
    logic              mosi_q;
    logic [DATA_W-1:0] txb;
    logic [DATA_W-1:0] rxb;
    logic [DATA_W-1:0] rx_next;
    logic [IDX_W-1:0]  bit_k;
    logic [IDX_W-1:0]  rx_idx;
    logic              lead;
    logic              trail;
    logic              sample;

    assign bit_k  = half[H_W-1:1];
    assign lead   = tick && !half[0];
    assign trail  = tick && half[0];
    assign sample = mode.cpha ? trail : lead;
    assign rx_idx = mode.lsb_first ? bit_k : (IDX_W'(DATA_W - 1) - bit_k);
    assign done   = trail && (half == H_W'(2 * DATA_W - 1));

    always_comb begin
        rx_next = rxb;
        if (sample) begin
            rx_next[rx_idx] = miso;
        end
    end

    assign done_data = rx_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            half   <= '0;
            phase  <= 1'b0;
            mosi_q <= 1'b0;
            txb    <= '0;
            rxb    <= '0;
        end else begin
            if (tick) begin
                phase <= ~phase;
                half  <= half + H_W'(1);
                rxb   <= rx_next;
                if (!mode.cpha && trail && !done) begin
                    mosi_q <= bit_at(txb, bit_k + IDX_W'(1), mode.lsb_first);
                end
                if (mode.cpha && lead) begin
                    mosi_q <= bit_at(txb, bit_k, mode.lsb_first);
                end
            end
            if (done) begin
                busy <= 1'b0;
            end
            if (load) begin
                busy <= 1'b1;
                half <= '0;
                txb  <= load_data;
                if (!mode.cpha) begin
                    mosi_q <= bit_at(load_data, '0, mode.lsb_first);
                end
            end
        end
    end

    assign sck  = mode.cpol ^ phase;
    assign mosi = mosi_q;

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> sck == mode.cpol); // R3
endmodule

// File: rtl/spim_rxq.sv
module spim_rxq
    import spim_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              rd,
    output logic [DATA_W-1:0] head,
    output logic              nonempty,
    output logic              ovr
);
    localparam int SLOTS = DEPTH + 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [DATA_W-1:0] mem [SLOTS];
    logic [CNT_W-1:0]  count;
    logic              pop;
    logic              full;
    logic              clobber;
    logic [CNT_W-1:0]  wr_idx;

    assign pop      = rd && (count != '0);
    assign full     = (count == CNT_W'(SLOTS));
    assign clobber  = push && full && !pop;
    assign wr_idx   = count - CNT_W'(pop);
    assign head     = mem[0];
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (pop) begin
            for (int i = 0; i < SLOTS - 1; i++) begin
                mem[i] <= mem[i+1];
            end
        end
        if (clobber) begin
            mem[SLOTS-1] <= din;
        end else if (push) begin
            mem[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (!clobber) begin
                count <= count + CNT_W'(push) - CNT_W'(pop);
            end
            if (clobber) begin
                ovr <= 1'b1;
            end else if (pop) begin
                ovr <= 1'b0;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(SLOTS)); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst) push && full && !rd |=> ovr); // R10
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst) !push && !rd |=> $stable(count)); // R9
endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              miso,
    output logic [DATA_W-1:0] rd_data,
    output logic              txbuf_empty,
    output logic              rx_ready,
    output logic              overrun,
    output logic              sck,
    output logic              mosi,
    output logic              mosi_oe
);
    spi_mode_t         mode;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              wr_ok;
    logic              busy;
    logic              done;
    logic              tick;
    logic              sh_load;
    logic [DATA_W-1:0] rx_byte;

    assign mode    = '{cpol: cpol, cpha: cpha, lsb_first: lsb_first};
    assign wr_ok   = wr_en && tx_en;
    assign sh_load = tx_en && hold_valid && (!busy || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else begin
            if (wr_ok) begin
                hold_valid <= 1'b1;
                hold_data  <= wr_data;
            end else if (sh_load) begin
                hold_valid <= 1'b0;
            end
        end
    end

    spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (clk_div),
        .tick (tick)
    );

    spim_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .tick      (tick),
        .load      (sh_load),
        .load_data (hold_data),
        .miso      (miso),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .done      (done),
        .done_data (rx_byte)
    );

    spim_rxq #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .push     (done && rx_en),
        .din      (rx_byte),
        .rd       (rd_en),
        .head     (rd_data),
        .nonempty (rx_ready),
        .ovr      (overrun)
    );

    assign txbuf_empty = !hold_valid;
    assign mosi_oe     = tx_en;

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
        hold_valid && tx_en && !busy && !wr_en |=> txbuf_empty); // R6
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        done && hold_valid && tx_en |=> busy); // R7
    AST_TX_GATE: assert property (@(posedge clk) disable iff (rst)
        !tx_en && !busy |=> !busy); // R2
endmodule

// File: tb/sim_spim_core.sv
module sim_spim_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [11:0] clk_div = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       miso = 1'b0;
    logic [7:0] rd_data;
    logic       txbuf_empty, rx_ready, overrun, sck, mosi, mosi_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spim_core u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .clk_div(clk_div), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .miso(miso), .rd_data(rd_data), .txbuf_empty(txbuf_empty),
        .rx_ready(rx_ready), .overrun(overrun), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe)
    );

    // {cpol, cpha, lsb_first, clk_div, tx byte}
    localparam logic [22:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 12'd0, 8'hA5},
        {1'b0, 1'b1, 1'b0, 12'd1, 8'h3C},
        {1'b1, 1'b0, 1'b0, 12'd2, 8'h96},
        {1'b1, 1'b1, 1'b0, 12'd0, 8'h5A},
        {1'b0, 1'b0, 1'b1, 12'd3, 8'hC1},
        {1'b0, 1'b1, 1'b1, 12'd0, 8'h7E},
        {1'b1, 1'b0, 1'b1, 12'd1, 8'h18},
        {1'b1, 1'b1, 1'b1, 12'd5, 8'hE7}
    };

    function automatic logic [7:0] resp(int i);
        return 8'h3C ^ 8'(i * 8'h47);
    endfunction

    function automatic logic sbit(logic [7:0] b, int k, logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // cycle counter and slave model
    int cyc = 0;
    always @(posedge clk) cyc++;

    int e = 0, nbytes = 0, edges = 0, last_cyc = 0, gmin = 1000000, gmax = 0;
    logic have_last = 1'b0, meas_on = 1'b0, prev_ph = 1'b0;
    logic [7:0] cap = '0;
    logic [7:0] capq [8];

    always @(negedge clk) begin
        if (rst) begin
            prev_ph = sck ^ cpol;
            e = 0;
        end else begin
            if ((sck ^ cpol) !== prev_ph) begin
                int kk;
                logic lead;
                edges++;
                if (meas_on) begin
                    if (have_last) begin
                        if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
                        if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
                    end
                    have_last = 1'b1;
                    last_cyc = cyc;
                end
                kk = e / 2;
                lead = (e % 2 == 0);
                if (cpha ? !lead : lead) cap[lsb_first ? kk : 7 - kk] = mosi;
                if (!cpha && !lead && e != 15) miso = sbit(resp(nbytes), kk + 1, lsb_first);
                if (cpha && lead) miso = sbit(resp(nbytes), kk, lsb_first);
                e++;
                if (e == 16) begin
                    e = 0;
                    capq[nbytes % 8] = cap;
                    nbytes++;
                end
            end
            prev_ph = sck ^ cpol;
            if (e == 0 && !cpha) miso = sbit(resp(nbytes), 0, lsb_first);
        end
    end

    task automatic cfg(logic p, logic h, logic l, logic [11:0] d);
        @(posedge clk); #1;
        cpol = p; cpha = h; lsb_first = l; clk_div = d;
    endtask

    task automatic meas_start();
        meas_on = 1'b1; have_last = 1'b0; gmin = 1000000; gmax = 0;
    endtask

    task automatic write(logic [7:0] d);
        @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic read_chk(string tag, logic [7:0] exp);
        @(negedge clk);
        chk({tag, " rx_ready"}, 32'(rx_ready), 32'd1);
        chk(tag, 32'(rd_data), 32'(exp));
        @(posedge clk); #1; rd_en = 1'b1;
        @(posedge clk); #1; rd_en = 1'b0;
    endtask

    task automatic wait_bytes(int n);
        while (nbytes < n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n0, e0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txbuf_empty", 32'(txbuf_empty), 32'd1);
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 mosi/oe/sck", {29'd0, mosi, mosi_oe, sck}, 32'd0);

        // R2 writes dropped while transmitter disabled
        e0 = edges; n0 = nbytes;
        write(8'h55);
        repeat (40) @(negedge clk);
        chk("R2 no edges", 32'(edges - e0), 32'd0);
        chk("R2 txbuf_empty", 32'(txbuf_empty), 32'd1);
        chk("R2 mosi_oe low", 32'(mosi_oe), 32'd0);
        @(posedge clk); #1; tx_en = 1'b1; rx_en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2 no late start", 32'(edges - e0), 32'd0);
        chk("R2 mosi_oe high", 32'(mosi_oe), 32'd1);

        // vector table: R3, R4, R5
        for (int v = 0; v < 8; v++) begin
            logic [22:0] t;
            t = VEC[v];
            cfg(t[22], t[21], t[20], t[19:8]);
            meas_start();
            n0 = nbytes; e0 = edges;
            write(t[7:0]);
            wait_bytes(n0 + 1);
            chk("R4 mosi byte", 32'(capq[n0 % 8]), 32'(t[7:0]));
            chk("R3 min half", 32'(gmin), 32'(t[19:8]) + 32'd1);
            chk("R3 max half", 32'(gmax), 32'(t[19:8]) + 32'd1);
            chk("R3 edge count", 32'(edges - e0), 32'd16);
            chk("R3 idle level", 32'(sck), 32'(t[22]));
            meas_on = 1'b0;
            read_chk("R5 rx byte", resp(n0));
        end

        // R6 holding register flag
        cfg(1'b0, 1'b0, 1'b0, 12'd3);
        n0 = nbytes;
        write(8'h21);
        @(negedge clk);
        chk("R6 cleared on write", 32'(txbuf_empty), 32'd0);
        @(negedge clk);
        chk("R6 set on load", 32'(txbuf_empty), 32'd1);
        write(8'h42);
        @(negedge clk);
        chk("R6 cleared while busy", 32'(txbuf_empty), 32'd0);
        repeat (10) @(negedge clk);
        chk("R6 held while busy", 32'(txbuf_empty), 32'd0);
        wait_bytes(n0 + 2);
        chk("R6 second byte sent", 32'(capq[(n0 + 1) % 8]), 32'h42);
        read_chk("R9 first", resp(n0));
        read_chk("R9 second", resp(n0 + 1));

        // R8 receiver disabled
        @(posedge clk); #1; rx_en = 1'b0;
        n0 = nbytes; e0 = edges;
        write(8'h99);
        wait_bytes(n0 + 1);
        chk("R8 clock still runs", 32'(edges - e0), 32'd16);
        chk("R8 nothing stored", 32'(rx_ready), 32'd0);
        @(posedge clk); #1; rx_en = 1'b1;

        // R7 / R10 four-byte burst, no reads
        cfg(1'b0, 1'b0, 1'b0, 12'd1);
        meas_start();
        n0 = nbytes; e0 = edges;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            while (!txbuf_empty) @(negedge clk);
            write(8'h10 + 8'(i));
        end
        wait_bytes(n0 + 4);
        meas_on = 1'b0;
        chk("R7 gap min", 32'(gmin), 32'd2);
        chk("R7 gap max", 32'(gmax), 32'd2);
        chk("R7 edges", 32'(edges - e0), 32'd64);
        chk("R7 last byte sent", 32'(capq[(n0 + 3) % 8]), 32'h13);
        chk("R10 overrun set", 32'(overrun), 32'd1);
        read_chk("R10 byte1 kept", resp(n0));
        @(negedge clk);
        chk("R10 overrun cleared", 32'(overrun), 32'd0);
        read_chk("R10 byte2 kept", resp(n0 + 1));
        read_chk("R10 byte4 after loss", resp(n0 + 3));
        @(negedge clk);
        chk("R9 empty after reads", 32'(rx_ready), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule